// File: doc/BRIEF.md
# Daisy-Chainable Serial Command Slave

This block is the serial front end of a device meant to be wired in series with identical devices. All devices share one active-low select line and one serial clock. The first device takes data from the host, and each later device takes its data input from the serial output of the device before it. Each device accepts one 16-bit command per command-cycle of 16 clock pulses. It plays back the word it held before, so a word moves one device further down the chain with every command-cycle. The host can therefore give every device its own command with one select line and one frame of N words.

The select, clock and data pins are brought into the system clock domain through a short synchronizer, and all the logic runs on the system clock. While select is low, incoming words are only shifted through the device and nothing is executed. When select is released, a device that has received a whole number of words copies its last complete word to a parallel command output and raises an execute strobe for exactly one system clock. A release after a partial word drops that word. Decoding the command is left to the logic that follows.

Top module: `daisy_spi_slave`

## Requirements
- R1: While `csN` is low, each rising edge of `sclk` shifts `din` into a 16-bit register, most significant bit first. The high and low phases of `sclk` each last at least four system clocks.
- R2: `dout` changes only after a falling edge of `sclk`, where it takes the register's most significant bit. A word shifted in during command-cycle k therefore appears on `dout`, most significant bit first, during command-cycle k+1, and `dout` is stable when the following device samples it.
- R3: A falling edge of `csN` clears the bit counter and the shift register, so `dout` carries all zeros during the first command-cycle of a frame.
- R4: While `csN` stays low, no execute strobe is produced and `cmdWord` keeps its previous value, whatever number of words is shifted.
- R5: On a rising edge of `csN` after a whole, non-zero number of 16-bit words, `cmdWord` takes the last complete word and `execPulse` is high for exactly one system clock.
- R6: On a rising edge of `csN` after a bit count that is not a multiple of 16, the partial word is dropped: no strobe, and `cmdWord` is unchanged. The next frame starts counting from zero.
- R7: While `csN` is high, `dout` is held low.
- R8: After reset, `cmdWord` is zero, and `execPulse` and `dout` are low.
- R9: A select pulse with no `sclk` edges produces no strobe and leaves `cmdWord` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select shared by the chain |
| sclk | input | 1 | Serial clock, idle low |
| din | input | 1 | Serial data in, from the host or the previous device |
| dout | output | 1 | Serial data out, to the next device |
| cmdWord | output | 16 | Last executed command word |
| execPulse | output | 1 | One-clock strobe marking a new `cmdWord` |

## Verification
Each pin change passes two synchronizer stages and one edge detect, so `dout` and the strobe act on the third system clock edge after an input change. The bench reads `dout` at the end of each eight-clock low phase of `sclk`, five clocks after the new bit is due. It expects the strobe within the twelve clocks that follow the release of select, and it checks that the scoreboard queue is empty at that point. A strobe that arrives with nothing queued is counted as a violation of R4. Each check on `dout` compares a whole 16-bit word, collected at those sample points, with the word sent one command-cycle earlier.

// File: rtl/daisy_spi_pkg.sv
package daisy_spi_pkg;

  // Strobes from the control to the datapath, one system clock each.
  typedef struct packed {
    logic clearAll;   // select fell: empty shift register and output bit
    logic shiftIn;    // sclk rose while selected: take one data bit
    logic driveOut;   // sclk fell while selected: present register MSB
    logic quietOut;   // select rose: force serial output low
    logic commit;     // select rose on a word boundary: execute
  } dcStrobe_t;

endpackage

// File: rtl/daisy_sync.sv
module daisy_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rawIn,
  output logic [W-1:0] syncOut
);

  logic [W-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else if (s == 0) pipe[s] <= rawIn;
        else pipe[s] <= pipe[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign syncOut = pipe[STAGES-1];

endmodule

// File: rtl/daisy_ctrl.sv
module daisy_ctrl
  import daisy_spi_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      csLvl,
  input  logic      sclkLvl,
  output dcStrobe_t strb
);

  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic             csPrev;
  logic             sclkPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             wordSeen;

  logic csRise, csFall, sclkRise, sclkFall, selected, lastBit;

  always_comb begin
    csRise   = csLvl && !csPrev;
    csFall   = !csLvl && csPrev;
    sclkRise = sclkLvl && !sclkPrev;
    sclkFall = !sclkLvl && sclkPrev;
    selected = !csLvl && !csFall;
    lastBit  = (bitCnt == LAST_BIT);
  end

  always_comb begin
    strb          = '0;
    strb.clearAll = csFall;
    strb.shiftIn  = selected && sclkRise;
    strb.driveOut = selected && sclkFall;
    strb.quietOut = csRise;
    strb.commit   = csRise && wordSeen && (bitCnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csLvl;
      sclkPrev <= sclkLvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt   <= '0;
      wordSeen <= 1'b0;
    end else if (csFall) begin
      bitCnt   <= '0;
      wordSeen <= 1'b0;
    end else if (strb.shiftIn) begin
      bitCnt   <= lastBit ? '0 : bitCnt + 1'b1;
      wordSeen <= wordSeen || lastBit;
    end
  end

endmodule

// File: rtl/daisy_datapath.sv
module daisy_datapath
  import daisy_spi_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dcStrobe_t         strb,
  input  logic              dinLvl,
  output logic              serOut,
  output logic [WORD_W-1:0] cmdReg,
  output logic              execReg
);

  logic [WORD_W-1:0] shReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shReg <= '0;
    else if (strb.clearAll) shReg <= '0;
    else if (strb.shiftIn) shReg <= {shReg[WORD_W-2:0], dinLvl};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) serOut <= 1'b0;
    else if (strb.clearAll || strb.quietOut) serOut <= 1'b0;
    else if (strb.driveOut) serOut <= shReg[WORD_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdReg  <= '0;
      execReg <= 1'b0;
    end else begin
      execReg <= strb.commit;
      if (strb.commit) cmdReg <= shReg;
    end
  end

endmodule

// File: rtl/daisy_spi_slave.sv
module daisy_spi_slave
  import daisy_spi_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic [WORD_W-1:0] cmdWord,
  output logic              execPulse
);

  localparam int           PIN_N   = 3;
  localparam logic [2:0]   PIN_RST = 3'b100;  // select idle high, clock and data low

  logic [PIN_N-1:0] pinSync;
  logic             csLvl, sclkLvl, dinLvl;
  dcStrobe_t        strb;

  daisy_sync #(
    .W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)
  ) u_sync (
    .clk(clk), .rst_n(rst_n),
    .rawIn({csN, sclk, din}),
    .syncOut(pinSync)
  );

  assign {csLvl, sclkLvl, dinLvl} = pinSync;

  daisy_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .csLvl(csLvl), .sclkLvl(sclkLvl),
    .strb(strb)
  );

  daisy_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .strb(strb), .dinLvl(dinLvl),
    .serOut(dout), .cmdReg(cmdWord), .execReg(execPulse)
  );

endmodule

// File: rtl/daisy_spi_checker.sv
module daisy_spi_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csLvl,
  input logic              sclkLvl,
  input logic              dout,
  input logic [WORD_W-1:0] cmdWord,
  input logic              execPulse
);

  assert_strobe_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    execPulse |=> !execPulse);

  assert_no_exec_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    execPulse |-> csLvl);

  assert_cmd_only_on_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmdWord) |-> execPulse);

  assert_dout_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (csLvl && $past(csLvl)) |-> !dout);

  assert_dout_moves_low_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> (!sclkLvl || csLvl || $past(csLvl)));

endmodule

bind daisy_spi_slave daisy_spi_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .csLvl(csLvl), .sclkLvl(sclkLvl),
  .dout(dout), .cmdWord(cmdWord), .execPulse(execPulse)
);

// File: tb/sim_daisy_spi_slave.sv
module sim_daisy_spi_slave;
  localparam int W    = 16;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, csN = 1'b1, sclk = 1'b0, din = 1'b0;
  logic         dout;
  logic [W-1:0] cmdWord;
  logic         execPulse;

  int           nRun = 0, nFail = 0;
  logic [W-1:0] expQ[$];
  logic         prevPulse = 1'b0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  daisy_spi_slave u0 (
    .clk(clk), .rst_n(rst_n), .csN(csN), .sclk(sclk), .din(din),
    .dout(dout), .cmdWord(cmdWord), .execPulse(execPulse)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp, input string what);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops an expected word for every execute strobe.
  always @(negedge clk) begin : monitor
    logic [W-1:0] e;
    if (rst_n && !done && execPulse) begin
      check(!prevPulse, "R5", W'(prevPulse), '0, "strobe longer than one clock");
      if (expQ.size() == 0) check(1'b0, "R4", cmdWord, '0, "unexpected execute");
      else begin
        e = expQ.pop_front();
        check(cmdWord == e, "R5", cmdWord, e, "executed word");
      end
    end
    prevPulse <= execPulse;
  end

  task automatic select();
    csN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic sendWord(input logic [W-1:0] w, input logic [W-1:0] expOut, input string req);
    logic [W-1:0] got = '0;
    for (int i = W - 1; i >= 0; i--) begin
      din = w[i];
      waitClk(HALF - 1);
      got[i] = dout;
      waitClk(1);
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
    check(got == expOut, req, got, expOut, "DOUT word");
  endtask

  task automatic sendBits(input logic [W-1:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      din = w[W-1-i];
      waitClk(HALF);
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic release_cs(input bit expectExec, input logic [W-1:0] word);
    if (expectExec) expQ.push_back(word);
    csN = 1'b1;
    din = 1'b0;
    waitClk(12);
    check(expQ.size() == 0, "R5", W'(expQ.size()), '0, "execute not seen in window");
    check(dout == 1'b0, "R7", W'(dout), '0, "DOUT while deselected");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin : driver
    waitClk(3);
    rst_n = 1'b1;
    waitClk(2);
    check(cmdWord == '0, "R8", cmdWord, '0, "reset cmdWord");
    check(execPulse == 1'b0, "R8", W'(execPulse), '0, "reset strobe");
    check(dout == 1'b0, "R8", W'(dout), '0, "reset DOUT");

    // Single word: zeros on DOUT, MSB-first capture
    select();
    sendWord(16'h7FF8, 16'h0000, "R3");
    release_cs(1'b1, 16'h7FF8);
    check(cmdWord == 16'h7FF8, "R1", cmdWord, 16'h7FF8, "MSB-first word");

    // Three-word chain: one command-cycle delay, no execute while selected
    select();
    sendWord(16'h3FF8, 16'h0000, "R3");
    sendWord(16'h3000, 16'h3FF8, "R2");
    check(cmdWord == 16'h7FF8, "R4", cmdWord, 16'h7FF8, "cmdWord held while selected");
    sendWord(16'h2000, 16'h3000, "R2");
    release_cs(1'b1, 16'h2000);

    // Partial trailing word is dropped
    select();
    sendWord(16'hA5A5, 16'h0000, "R3");
    sendWord(16'h5A5A, 16'hA5A5, "R2");
    sendBits(16'hFFFF, 5);
    release_cs(1'b0, '0);
    check(cmdWord == 16'h2000, "R6", cmdWord, 16'h2000, "cmdWord after partial");

    // Whole frame after a partial one counts from zero
    select();
    sendWord(16'h1234, 16'h0000, "R6");
    release_cs(1'b1, 16'h1234);

    // Empty select pulse
    select();
    release_cs(1'b0, '0);
    check(cmdWord == 16'h1234, "R9", cmdWord, 16'h1234, "cmdWord after empty select");

    // Extreme patterns
    select();
    sendWord(16'hFFFF, 16'h0000, "R3");
    sendWord(16'h0000, 16'hFFFF, "R2");
    sendWord(16'hFFFF, 16'h0000, "R2");
    release_cs(1'b1, 16'hFFFF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule